// File: doc/BRIEF.md
# UART Line, Modem and FIFO Control Unit with Single-Bit Aliases

This block holds the control state of a 16550-style UART: the line control byte, the modem control bits and the write-only FIFO control byte. It also offers three single-bit alias locations, for request-to-send, break and DMA signalling mode. Software can flip one of these bits without first reading, masking and rewriting the wider register. Each alias and its parent register share one storage bit, so a write through either location is visible through both.

From that state the unit drives the pins around the serializer. It produces the active-low request-to-send output, gated by the receive FIFO threshold when automatic flow control is active. It forces the serial output low during a break, drives the active-low infrared output, and brings out the DMA signalling mode select and the full FIFO control byte. In loopback it holds the external pins idle and steers transmit data, break and request-to-send onto internal receiver-side signals. The serializer, FIFOs, baud generator and DMA handshake sit outside.

Register access uses a simple bus. A write is taken on the rising clock edge while `wrEn` is high. Read data is combinational from `addr`.

Top module: `uart_ctl_unit`

## Requirements
- R1: Address 3 (alias RTS, bit 0) and modem control bit 1 (address 1) are one storage bit. A write to either location is visible on a read of the other from the next cycle on.
- R2: With modem control bit 5 (auto flow) clear and loopback clear, `rtsN` is the inverse of the RTS bit. `rxAboveThr` has no effect.
- R3: When modem control bit 5 and FIFO control bit 0 (FIFO enable) are both set, and loopback is clear, `rtsN` is high while `rxAboveThr` is high. Otherwise it is the inverse of the RTS bit. If either bit is clear, the threshold is ignored.
- R4: With modem control bit 4 (loopback) set, `rtsN` and `serOut` are held high, `lbCtsN` is the inverse of the RTS bit and `lbRxData` carries `txData`. Outside loopback, `lbCtsN` and `lbRxData` are high.
- R5: Address 4 (alias break, bit 0) and line control bit 6 are one storage bit. While break is set and loopback is clear, `serOut` is 0. Otherwise, outside loopback, `serOut` follows `txData`.
- R6: While break is set in loopback, `serOut` stays high and `lbRxData` is 0.
- R7: With modem control bit 6 (infrared) set and loopback clear, `irOutN` is low exactly when `irPulse` is high and either break is set or `txData` is 0. In every other case `irOutN` is high.
- R8: Address 5 (alias DMA mode, bit 0) and FIFO control bit 3 are one storage bit, driven on `dmaMode`. A write through the alias changes only that bit of `fifoCtrlOut`. A full write to address 2 replaces all eight bits, including bit 3.
- R9: After reset all control bits are 0. `rtsN` is high, `dmaMode` is 0 and `fifoCtrlOut` is 0. Reads of addresses 3 to 5 return 0 in bits 15:1 at all times.
- R10: Address 0 is line control (8 bits) and address 1 is modem control (bits 6:0). Address 2 (FIFO control) reads 0. Addresses 6 and 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| rxAboveThr | input | 1 | Receive FIFO at or above its trigger level |
| txData | input | 1 | Serial data from the transmitter |
| irPulse | input | 1 | Infrared pulse timing source |
| rtsN | output | 1 | Request to send, active low |
| lbCtsN | output | 1 | Looped-back modem input to the receiver, active low |
| serOut | output | 1 | External serial output |
| lbRxData | output | 1 | Looped-back serial data to the receiver |
| irOutN | output | 1 | Infrared output, active low |
| dmaMode | output | 1 | DMA signalling mode select |
| fifoCtrlOut | output | 8 | Stored FIFO control byte |

## Verification
The assertions check the port-level relations on every cycle. These include the idle `rtsN` and `serOut` whenever a loopback signal is active, `rtsN` rising after RTS is cleared through the alias, and the break forcing one of the two data paths low. They also cover the alias DMA write leaving the other seven FIFO control bits intact, the infrared output idling once infrared mode is turned off, and zero upper bits on alias reads. The bench scenarios are needed for the two-way coherence of each alias with its parent register, the threshold gating under each combination of auto flow and FIFO enable, the infrared pulse patterns, and the proof that unmapped writes leave every register untouched.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  // register map
  localparam int ADR_LINE  = 0;
  localparam int ADR_MODEM = 1;
  localparam int ADR_FIFO  = 2;
  localparam int ADR_SHRTS = 3;
  localparam int ADR_SHBRK = 4;
  localparam int ADR_SHDMA = 5;

  localparam int CTRL_W = 8;
  localparam int MODEM_W = 7;

  // bit positions the output logic decodes
  localparam int MC_RTS  = 1;
  localparam int MC_LOOP = 4;
  localparam int MC_AFC  = 5;
  localparam int MC_IR   = 6;
  localparam int LC_BRK  = 6;
  localparam int FC_EN   = 0;
  localparam int FC_DMA  = 3;

  typedef struct packed {
    logic wrLine;
    logic wrModem;
    logic wrFifo;
    logic wrShRts;
    logic wrShBrk;
    logic wrShDma;
  } strobeT;
endpackage

// File: rtl/uart_ctl_decode.sv
module uart_ctl_decode
  import uart_ctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      stb.wrLine  = (addr == ADDR_W'(ADR_LINE));
      stb.wrModem = (addr == ADDR_W'(ADR_MODEM));
      stb.wrFifo  = (addr == ADDR_W'(ADR_FIFO));
      stb.wrShRts = (addr == ADDR_W'(ADR_SHRTS));
      stb.wrShBrk = (addr == ADDR_W'(ADR_SHBRK));
      stb.wrShDma = (addr == ADDR_W'(ADR_SHDMA));
    end
  end
endmodule

// File: rtl/uart_ctl_datapath.sv
module uart_ctl_datapath
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxAboveThr,
  input  logic              txData,
  input  logic              irPulse,
  output logic              rtsN,
  output logic              lbCtsN,
  output logic              serOut,
  output logic              lbRxData,
  output logic              irOutN,
  output logic              dmaMode,
  output logic [CTRL_W-1:0] fifoCtrlOut
);
  logic [CTRL_W-1:0]  lineQ;
  logic [MODEM_W-1:0] modemQ;
  logic [CTRL_W-1:0]  fifoQ;
  logic unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:CTRL_W];

  // shared storage: each alias writes one bit of its parent register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ  <= '0;
      modemQ <= '0;
      fifoQ  <= '0;
    end else begin
      if (stb.wrLine)       lineQ <= wrData[CTRL_W-1:0];
      else if (stb.wrShBrk) lineQ[LC_BRK] <= wrData[0];

      if (stb.wrModem)      modemQ <= wrData[MODEM_W-1:0];
      else if (stb.wrShRts) modemQ[MC_RTS] <= wrData[0];

      if (stb.wrFifo)       fifoQ <= wrData[CTRL_W-1:0];
      else if (stb.wrShDma) fifoQ[FC_DMA] <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(ADR_LINE):  rdData = DATA_W'(lineQ);
      ADDR_W'(ADR_MODEM): rdData = DATA_W'(modemQ);
      ADDR_W'(ADR_SHRTS): rdData = DATA_W'(modemQ[MC_RTS]);
      ADDR_W'(ADR_SHBRK): rdData = DATA_W'(lineQ[LC_BRK]);
      ADDR_W'(ADR_SHDMA): rdData = DATA_W'(fifoQ[FC_DMA]);
      default:            rdData = '0;
    endcase
  end

  logic loopOn, brkOn, rtsBit, thrGate, irOn;
  assign loopOn  = modemQ[MC_LOOP];
  assign brkOn   = lineQ[LC_BRK];
  assign rtsBit  = modemQ[MC_RTS];
  assign irOn    = modemQ[MC_IR] & ~loopOn;
  assign thrGate = modemQ[MC_AFC] & fifoQ[FC_EN] & rxAboveThr;

  assign rtsN     = loopOn | thrGate | ~rtsBit;
  assign lbCtsN   = loopOn ? ~rtsBit : 1'b1;
  assign serOut   = loopOn ? 1'b1 : (txData & ~brkOn);
  assign lbRxData = loopOn ? (txData & ~brkOn) : 1'b1;
  assign irOutN   = irOn ? ~(irPulse & (brkOn | ~txData)) : 1'b1;

  assign dmaMode     = fifoQ[FC_DMA];
  assign fifoCtrlOut = fifoQ;
endmodule

// File: rtl/uart_ctl_unit.sv
module uart_ctl_unit
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxAboveThr,
  input  logic              txData,
  input  logic              irPulse,
  output logic              rtsN,
  output logic              lbCtsN,
  output logic              serOut,
  output logic              lbRxData,
  output logic              irOutN,
  output logic              dmaMode,
  output logic [7:0]        fifoCtrlOut
);
  strobeT stb;

  uart_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  uart_ctl_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rxAboveThr(rxAboveThr), .txData(txData),
    .irPulse(irPulse), .rtsN(rtsN), .lbCtsN(lbCtsN), .serOut(serOut),
    .lbRxData(lbRxData), .irOutN(irOutN), .dmaMode(dmaMode),
    .fifoCtrlOut(fifoCtrlOut)
  );
endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              rtsN,
  input logic              lbCtsN,
  input logic              serOut,
  input logic              lbRxData,
  input logic              irOutN,
  input logic [7:0]        fifoCtrlOut
);
  // R1: clearing RTS through the alias releases rtsN
  a_r1_alias_clear_rts: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(3) && !wrData[0]) |=> rtsN);

  // R4: an active looped modem input means the external RTS is idle
  a_r4_loop_rts_idle: assert property (@(posedge clk) disable iff (!rstN)
    !lbCtsN |-> rtsN);

  // R4 and R6: low looped data means the external line is idle
  a_r6_loop_ser_idle: assert property (@(posedge clk) disable iff (!rstN)
    !lbRxData |-> serOut);

  // R5 and R6: setting break drives one of the two data paths low
  a_r5_break_forces_low: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(4) && wrData[0]) |=> (!serOut || !lbRxData));

  // R8: the alias DMA write touches bit 3 only
  a_r8_dma_alias_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(5)) |=>
      (fifoCtrlOut == {$past(fifoCtrlOut[7:4]), $past(wrData[0]), $past(fifoCtrlOut[2:0])}));

  // R7: infrared mode off leaves the infrared output idle
  a_r7_ir_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(1) && !wrData[6]) |=> irOutN);

  // R9: alias locations have zero upper bits
  a_r9_alias_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= ADDR_W'(3) && addr <= ADDR_W'(5)) |-> (rdData[DATA_W-1:1] == '0));
endmodule

bind uart_ctl_unit uart_ctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .rtsN(rtsN), .lbCtsN(lbCtsN), .serOut(serOut),
  .lbRxData(lbRxData), .irOutN(irOutN), .fifoCtrlOut(fifoCtrlOut)
);

// File: tb/uart_ctl_unit_bench.sv
module uart_ctl_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic rxAboveThr = 1'b0, txData = 1'b1, irPulse = 1'b0;
  logic rtsN, lbCtsN, serOut, lbRxData, irOutN, dmaMode;
  logic [7:0] fifoCtrlOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_ctl_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_uart_ctl_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rxAboveThr(rxAboveThr), .txData(txData),
    .irPulse(irPulse), .rtsN(rtsN), .lbCtsN(lbCtsN), .serOut(serOut),
    .lbRxData(lbRxData), .irOutN(irOutN), .dmaMode(dmaMode),
    .fifoCtrlOut(fifoCtrlOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // write lands on the posedge between two negedges
  task automatic regWrite(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    #1;
  endtask

  task automatic regRead(int a, output logic [DATA_W-1:0] d);
    addr = ADDR_W'(a);
    #1;
    d = rdData;
  endtask

  task automatic setPins(logic thr, logic tx, logic ir);
    rxAboveThr = thr; txData = tx; irPulse = ir;
    #1;
  endtask

  task automatic testReset();
    logic [DATA_W-1:0] d;
    check("R9 rtsN", 32'(rtsN), 1);
    check("R9 dmaMode", 32'(dmaMode), 0);
    check("R9 fifoCtrlOut", 32'(fifoCtrlOut), 0);
    check("R5 serOut follows tx", 32'(serOut), 1);
    for (int a = 0; a < 6; a++) begin
      regRead(a, d);
      check("R9 reset read", 32'(d), 0);
    end
  endtask

  task automatic testRtsAlias();
    logic [DATA_W-1:0] d;
    regWrite(3, 16'hFFFF);
    regRead(1, d);
    check("R1 modem bit1 via alias", 32'(d), 32'h02);
    regRead(3, d);
    check("R9 alias upper zero", 32'(d), 1);
    check("R2 rtsN low", 32'(rtsN), 0);
    setPins(1'b1, 1'b1, 1'b0);
    check("R2 threshold ignored", 32'(rtsN), 0);
    regWrite(1, 16'h0000);
    regRead(3, d);
    check("R1 alias via modem", 32'(d), 0);
    check("R2 rtsN high", 32'(rtsN), 1);
    setPins(1'b0, 1'b1, 1'b0);
  endtask

  task automatic testAutoFlow();
    regWrite(2, 16'h0001);
    regWrite(1, 16'h0022);
    setPins(1'b1, 1'b1, 1'b0);
    check("R3 gated high", 32'(rtsN), 1);
    setPins(1'b0, 1'b1, 1'b0);
    check("R3 below threshold", 32'(rtsN), 0);
    regWrite(2, 16'h0000);
    setPins(1'b1, 1'b1, 1'b0);
    check("R3 fifo off ignores thr", 32'(rtsN), 0);
    regWrite(2, 16'h0001);
    regWrite(1, 16'h0002);
    check("R3 afc off ignores thr", 32'(rtsN), 0);
    setPins(1'b0, 1'b1, 1'b0);
    regWrite(2, 16'h0000);
  endtask

  task automatic testLoopback();
    regWrite(1, 16'h0012);
    check("R4 rtsN idle", 32'(rtsN), 1);
    check("R4 lbCtsN", 32'(lbCtsN), 0);
    setPins(1'b0, 1'b0, 1'b0);
    check("R4 serOut idle", 32'(serOut), 1);
    check("R4 lbRxData tx0", 32'(lbRxData), 0);
    setPins(1'b0, 1'b1, 1'b0);
    check("R4 lbRxData tx1", 32'(lbRxData), 1);
    regWrite(1, 16'h0010);
    check("R4 lbCtsN rts0", 32'(lbCtsN), 1);
    regWrite(1, 16'h0002);
    setPins(1'b0, 1'b0, 1'b0);
    check("R4 lbRxData idle outside", 32'(lbRxData), 1);
    check("R4 lbCtsN idle outside", 32'(lbCtsN), 1);
    setPins(1'b0, 1'b1, 1'b0);
    regWrite(1, 16'h0000);
  endtask

  task automatic testBreak();
    logic [DATA_W-1:0] d;
    regWrite(4, 16'h0001);
    regRead(0, d);
    check("R5 line bit6 via alias", 32'(d), 32'h40);
    check("R5 serOut forced low", 32'(serOut), 0);
    regWrite(1, 16'h0010);
    check("R6 serOut idle in loop", 32'(serOut), 1);
    check("R6 lbRxData break", 32'(lbRxData), 0);
    regWrite(1, 16'h0000);
    regWrite(0, 16'h0003);
    regRead(4, d);
    check("R5 alias via line", 32'(d), 0);
    check("R5 serOut released", 32'(serOut), 1);
  endtask

  task automatic testInfrared();
    regWrite(1, 16'h0040);
    regWrite(4, 16'h0001);
    setPins(1'b0, 1'b1, 1'b1);
    check("R7 break pulse low", 32'(irOutN), 0);
    setPins(1'b0, 1'b1, 1'b0);
    check("R7 break pulse gap", 32'(irOutN), 1);
    regWrite(4, 16'h0000);
    setPins(1'b0, 1'b1, 1'b1);
    check("R7 data one no pulse", 32'(irOutN), 1);
    setPins(1'b0, 1'b0, 1'b1);
    check("R7 data zero pulse", 32'(irOutN), 0);
    regWrite(1, 16'h0000);
    check("R7 ir off", 32'(irOutN), 1);
    setPins(1'b0, 1'b1, 1'b0);
  endtask

  task automatic testDma();
    logic [DATA_W-1:0] d;
    regWrite(2, 16'h00C1);
    check("R8 dmaMode 0", 32'(dmaMode), 0);
    regWrite(5, 16'h0001);
    check("R8 alias keeps fields", 32'(fifoCtrlOut), 32'hC9);
    check("R8 dmaMode 1", 32'(dmaMode), 1);
    regRead(5, d);
    check("R8 alias read", 32'(d), 1);
    regRead(2, d);
    check("R10 fifo reads 0", 32'(d), 0);
    regWrite(2, 16'h0001);
    regRead(5, d);
    check("R8 full write updates alias", 32'(d), 0);
  endtask

  task automatic testUnmapped();
    logic [DATA_W-1:0] d;
    regWrite(0, 16'h0015);
    regWrite(1, 16'h0003);
    regWrite(6, 16'hFFFF);
    regWrite(7, 16'hFFFF);
    regRead(0, d);
    check("R10 line kept", 32'(d), 32'h15);
    regRead(1, d);
    check("R10 modem kept", 32'(d), 32'h03);
    check("R10 fifo kept", 32'(fifoCtrlOut), 32'h01);
    regRead(6, d);
    check("R10 addr6 reads 0", 32'(d), 0);
    regRead(7, d);
    check("R10 addr7 reads 0", 32'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testRtsAlias();
    testAutoFlow();
    testLoopback();
    testBreak();
    testInfrared();
    testDma();
    testUnmapped();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule